// File: doc/BRIEF.md
# Multi-User Inter-Processor Mailbox

This block passes 32-bit words between processors through a set of small hardware queues, reached over a plain register port. A sender stores a word by writing a queue's message register, and a receiver takes the oldest word by reading that same register. Each queue has two read-only registers. One shows whether the queue is full. The other shows how many words the queue holds.

Interrupts are delivered to a number of users. Every user sees two events per queue: a new word arrived, and a full queue gained a free slot. Each user has its own sticky event register, cleared by writing ones to it. Each user also has an enable mask with separate set and clear registers, and a level interrupt line that is high while any enabled event is pending. The number of queues, the number of users and the queue depth are parameters.

Register reads are registered: the value for a read strobe appears on `bus_rdata` after the next rising edge. A pop takes effect on that same edge.

Top module: `ipc_mailbox`

## Requirements
- R1: A read at offset 0x000 returns the constant revision word (parameter `REVISION`, default 0x0001_0400).
- R2: A write to offset 0x040+4*m pushes the word into queue m. A read of that offset pops the queues in arrival order and returns the popped word on `bus_rdata` one cycle after the read strobe.
- R3: Each queue holds `FIFO_DEPTH` words (default 4). A write to a full queue is dropped, so the word count stays at the depth and the stored words are unchanged.
- R4: A read of the message register of an empty queue returns 0 and leaves every queue count and every event bit unchanged.
- R5: The register at 0x080+4*m reads 1 when queue m is full and 0 otherwise.
- R6: The register at 0x0C0+4*m returns the number of words held in queue m, where 0 means empty.
- R7: An accepted push into queue m sets bit 2*m of every user's event register. A pop from a full queue m sets bit 2*m+1 of every user's event register.
- R8: The event register of user u is at 0x104+0x10*u. Writing a 1 to a bit clears that bit, and writing a 0 leaves the bit unchanged. An event in the same cycle takes precedence over the clear.
- R9: A write to the enable-set register at 0x108+0x10*u ORs the written bits into that user's mask. Reading either enable register returns the mask.
- R10: A write to the enable-clear register at 0x10C+0x10*u clears the mask bits written as 1 and keeps the other mask bits.
- R11: `irq_out[u]` is high exactly when some bit is set in both the event register and the mask of user u. It follows a register write or an event from the cycle after it.
- R12: A read of an unmapped offset returns 0. A write to an unmapped offset changes no state.
- R13: After reset, all queues are empty, all event and mask bits are 0, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | NUM_USER | Level interrupt, one line per user |

## Verification
A wrong queue pointer or count does not show at the ports right away. It shows on the next read, either as a word out of order on `bus_rdata` or as a wrong value in the count or full register. For that reason, every pop and every status read is compared one cycle after its strobe. A wrong event or mask bit shows on `irq_out` one cycle after the write or event that caused it, so the interrupt lines of all users are compared after every bus cycle. Words that were dropped or read back spuriously therefore show up within one access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [31:0] REV_ID = 32'h0001_0400;

  typedef enum logic [2:0] {
    RK_NONE, RK_REV, RK_MSG, RK_FST, RK_MST, RK_IST, RK_ESET, RK_ECLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [4:0]  idx;
  } reg_sel_t;

  // Offsets of the per-queue and per-user registers.
  function automatic logic [11:0] msg_off(int unsigned m);
    return 12'(32'h040 + 4 * m);
  endfunction

  function automatic logic [11:0] fst_off(int unsigned m);
    return 12'(32'h080 + 4 * m);
  endfunction

  function automatic logic [11:0] mst_off(int unsigned m);
    return 12'(32'h0C0 + 4 * m);
  endfunction

  function automatic logic [11:0] ist_off(int unsigned u);
    return 12'(32'h104 + 16 * u);
  endfunction

  function automatic logic [11:0] eset_off(int unsigned u);
    return 12'(32'h108 + 16 * u);
  endfunction

  function automatic logic [11:0] eclr_off(int unsigned u);
    return 12'(32'h10C + 16 * u);
  endfunction

  // Event bit positions inside a user register.
  function automatic int unsigned newmsg_bit(int unsigned m);
    return 2 * m;
  endfunction

  function automatic int unsigned notfull_bit(int unsigned m);
    return 2 * m + 1;
  endfunction

  // Address decode: region from the upper bits, index from the middle bits.
  function automatic reg_sel_t decode(logic [11:0] a, int unsigned nf, int unsigned nu);
    reg_sel_t   s;
    logic [11:0] o;
    s.kind = RK_NONE;
    s.idx  = '0;
    o      = a - 12'h100;
    if (a == 12'h000) begin
      s.kind = RK_REV;
    end else if (a[11:8] == 4'h0 && a[7:6] != 2'b00 && a[1:0] == 2'b00 &&
                 32'(a[5:2]) < nf) begin
      s.idx = 5'(a[5:2]);
      case (a[7:6])
        2'b01:   s.kind = RK_MSG;
        2'b10:   s.kind = RK_FST;
        default: s.kind = RK_MST;
      endcase
    end else if (a >= 12'h100 && 32'(o[11:4]) < nu) begin
      s.idx = 5'(o[8:4]);
      case (o[3:0])
        4'h4:    s.kind = RK_IST;
        4'h8:    s.kind = RK_ESET;
        4'hC:    s.kind = RK_ECLR;
        default: s.kind = RK_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic                           pop,
  input  logic [DW-1:0]                  wdata,
  output logic [DW-1:0]                  head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty,
  output logic                           push_ok,
  output logic                           pop_ok,
  output logic                           left_full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && !empty;
  assign left_full = pop_ok && full;
  assign head      = mem[rp];
  assign count     = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int unsigned NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] events,
  input  logic          st_clr_we,
  input  logic          en_set_we,
  input  logic          en_clr_we,
  input  logic [NB-1:0] wbits,
  output logic [NB-1:0] status,
  output logic [NB-1:0] enable,
  output logic          irq
);
  logic [NB-1:0] clr_mask;
  logic [NB-1:0] pending;

  assign clr_mask = st_clr_we ? wbits : '0;
  assign pending  = status & enable;
  assign irq      = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      // a fresh event outranks a simultaneous clear
      status <= (status & ~clr_mask) | events;
      if (en_set_we)      enable <= enable | wbits;
      else if (en_clr_we) enable <= enable & ~wbits;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int unsigned NUM_FIFO   = 4,
  parameter int unsigned NUM_USER   = 3,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter logic [31:0] REVISION   = mbx_pkg::REV_ID
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_USER-1:0] irq_out
);
  import mbx_pkg::*;

  localparam int unsigned NB = 2 * NUM_FIFO;
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  reg_sel_t sel;
  assign sel = decode(bus_addr, NUM_FIFO, NUM_USER);

  logic [NUM_FIFO-1:0]    push_req, pop_req, push_ok, pop_ok, left_full;
  logic [NUM_FIFO-1:0]    full_vec, empty_vec;
  logic [31:0]            head [NUM_FIFO];
  logic [CW-1:0]          cnt  [NUM_FIFO];
  logic [NUM_FIFO*CW-1:0] cnt_flat;
  logic [NB-1:0]          ev_vec;
  logic [NB-1:0]          st_arr [NUM_USER];
  logic [NB-1:0]          en_arr [NUM_USER];
  logic [NUM_USER*NB-1:0] st_flat, en_flat;
  logic [31:0]            rd_val;

  for (genvar m = 0; m < NUM_FIFO; m++) begin : g_fifo
    assign push_req[m] = bus_wr && sel.kind == RK_MSG && sel.idx == 5'(m);
    assign pop_req[m]  = bus_rd && sel.kind == RK_MSG && sel.idx == 5'(m);

    mbx_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_req[m]),
      .pop       (pop_req[m]),
      .wdata     (bus_wdata),
      .head      (head[m]),
      .count     (cnt[m]),
      .full      (full_vec[m]),
      .empty     (empty_vec[m]),
      .push_ok   (push_ok[m]),
      .pop_ok    (pop_ok[m]),
      .left_full (left_full[m])
    );

    assign ev_vec[newmsg_bit(m)]     = push_ok[m];
    assign ev_vec[notfull_bit(m)]    = left_full[m];
    assign cnt_flat[m*CW +: CW]      = cnt[m];
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    logic st_we, es_we, ec_we;
    assign st_we = bus_wr && sel.kind == RK_IST  && sel.idx == 5'(u);
    assign es_we = bus_wr && sel.kind == RK_ESET && sel.idx == 5'(u);
    assign ec_we = bus_wr && sel.kind == RK_ECLR && sel.idx == 5'(u);

    mbx_user_irq #(.NB(NB)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .events    (ev_vec),
      .st_clr_we (st_we),
      .en_set_we (es_we),
      .en_clr_we (ec_we),
      .wbits     (bus_wdata[NB-1:0]),
      .status    (st_arr[u]),
      .enable    (en_arr[u]),
      .irq       (irq_out[u])
    );

    assign st_flat[u*NB +: NB] = st_arr[u];
    assign en_flat[u*NB +: NB] = en_arr[u];
  end

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      RK_REV: rd_val = REVISION;
      RK_MSG, RK_FST, RK_MST: begin
        for (int m = 0; m < NUM_FIFO; m++) begin
          if (sel.idx == 5'(m)) begin
            if (sel.kind == RK_MSG)      rd_val = empty_vec[m] ? '0 : head[m];
            else if (sel.kind == RK_FST) rd_val = {31'b0, full_vec[m]};
            else                         rd_val = 32'(cnt[m]);
          end
        end
      end
      RK_IST, RK_ESET, RK_ECLR: begin
        for (int u = 0; u < NUM_USER; u++) begin
          if (sel.idx == 5'(u))
            rd_val = (sel.kind == RK_IST) ? 32'(st_arr[u]) : 32'(en_arr[u]);
        end
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_val : '0;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned NUM_FIFO   = 4,
  parameter int unsigned NUM_USER   = 3,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter logic [31:0] REVISION   = 32'h0,
  parameter int unsigned CW         = 3,
  parameter int unsigned NB         = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [11:0]            bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [NUM_USER-1:0]    irq_out,
  input logic [NUM_FIFO*CW-1:0] cnt_flat,
  input logic [NUM_FIFO-1:0]    full_vec,
  input logic [NB-1:0]          ev_vec,
  input logic [NUM_USER*NB-1:0] st_flat,
  input logic [NUM_USER*NB-1:0] en_flat
);
  import mbx_pkg::*;

  p_rev_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 12'h000 |=> bus_rdata == REVISION);

  for (genvar m = 0; m < NUM_FIFO; m++) begin : g_q
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[m*CW +: CW] <= CW'(FIFO_DEPTH));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full_vec[m] && bus_wr && !bus_rd && bus_addr == msg_off(m)
      |=> $stable(cnt_flat[m*CW +: CW]));

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == msg_off(m) && cnt_flat[m*CW +: CW] == '0
      |=> bus_rdata == 32'h0);
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_u
    for (genvar b = 0; b < NB; b++) begin : g_b
      p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vec[b] |=> st_flat[u*NB + b]);

      p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ist_off(u) && bus_wdata[b] && !ev_vec[b]
        |=> !st_flat[u*NB + b]);

      p_eset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == eset_off(u) && bus_wdata[b]
        |=> en_flat[u*NB + b]);
    end

    p_eclr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == eclr_off(u) && (&bus_wdata[NB-1:0])
      |=> !irq_out[u] && en_flat[u*NB +: NB] == '0);
  end
endmodule

bind ipc_mailbox mbx_checker #(
  .NUM_FIFO   (NUM_FIFO),
  .NUM_USER   (NUM_USER),
  .FIFO_DEPTH (FIFO_DEPTH),
  .REVISION   (REVISION),
  .CW         (CW),
  .NB         (NB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .cnt_flat  (cnt_flat),
  .full_vec  (full_vec),
  .ev_vec    (ev_vec),
  .st_flat   (st_flat),
  .en_flat   (en_flat)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  localparam int NF = 4;
  localparam int NU = 3;
  localparam int D  = 4;
  localparam logic [31:0] REV = 32'h0001_0400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NU-1:0] irq_out;

  int checks = 0;
  int errors = 0;

  // behavioural model
  logic [31:0] q [NF][$];
  logic [7:0]  st [NU];
  logic [7:0]  en [NU];

  always #10 clk = ~clk;

  ipc_mailbox #(.NUM_FIFO(NF), .NUM_USER(NU), .FIFO_DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [11:0] a_msg(int m);  return 12'(64 + 4*m);  endfunction
  function automatic logic [11:0] a_full(int m); return 12'(128 + 4*m); endfunction
  function automatic logic [11:0] a_cnt(int m);  return 12'(192 + 4*m); endfunction
  function automatic logic [11:0] a_ev(int u);   return 12'(260 + 16*u); endfunction
  function automatic logic [11:0] a_es(int u);   return 12'(264 + 16*u); endfunction
  function automatic logic [11:0] a_ec(int u);   return 12'(268 + 16*u); endfunction

  function automatic string tag_of(logic [11:0] a);
    int o;
    if (a == 0) return "R1";
    if (a >= 64 && a < 64 + 4*NF && a % 4 == 0) return "R2";
    if (a >= 128 && a < 128 + 4*NF && a % 4 == 0) return "R5";
    if (a >= 192 && a < 192 + 4*NF && a % 4 == 0) return "R6";
    o = int'(a) - 256;
    if (o >= 0 && o / 16 < NU) begin
      if (o % 16 == 4)  return "R8";
      if (o % 16 == 8)  return "R9";
      if (o % 16 == 12) return "R10";
    end
    return "R12";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one bus cycle; model advances alongside, outputs compared after the edge
  task automatic step(bit wr, bit rd, logic [11:0] a, logic [31:0] wd, string tag);
    logic [31:0] exp;
    logic [7:0]  ev;
    logic [NU-1:0] ei;
    int o, u, s;
    exp = '0;
    ev  = '0;
    o   = int'(a) - 256;
    if (a == 0) begin
      exp = REV;
    end else if (a >= 64 && a < 64 + 4*NF && a % 4 == 0) begin
      int m = (int'(a) - 64) / 4;
      if (rd && q[m].size() > 0) begin
        exp = q[m][0];
        if (q[m].size() == D) ev[2*m+1] = 1'b1;
        void'(q[m].pop_front());
      end
      if (wr && q[m].size() < D) begin
        q[m].push_back(wd);
        ev[2*m] = 1'b1;
      end
    end else if (a >= 128 && a < 128 + 4*NF && a % 4 == 0) begin
      exp = (q[(int'(a) - 128) / 4].size() == D) ? 32'd1 : 32'd0;
    end else if (a >= 192 && a < 192 + 4*NF && a % 4 == 0) begin
      exp = 32'(q[(int'(a) - 192) / 4].size());
    end else if (o >= 0 && o / 16 < NU) begin
      u = o / 16;
      s = o % 16;
      if (s == 4) begin
        exp = 32'(st[u]);
        if (wr) st[u] = st[u] & ~wd[7:0];
      end else if (s == 8) begin
        exp = 32'(en[u]);
        if (wr) en[u] = en[u] | wd[7:0];
      end else if (s == 12) begin
        exp = 32'(en[u]);
        if (wr) en[u] = en[u] & ~wd[7:0];
      end
    end
    for (int k = 0; k < NU; k++) st[k] = st[k] | ev;

    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (rd) chk(tag, bus_rdata, exp);
    for (int k = 0; k < NU; k++) ei[k] = |(st[k] & en[k]);
    chk("R11", 32'(irq_out), 32'(ei));
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag); step(1, 0, a, d, tag); endtask
  task automatic rd(logic [11:0] a, string tag);                 step(0, 1, a, 0, tag); endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NU; k++) begin st[k] = '0; en[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13", 32'(irq_out), 32'h0);
    for (int m = 0; m < NF; m++) rd(a_cnt(m), "R13");
    for (int u = 0; u < NU; u++) rd(a_ev(u), "R13");
    rd(a_es(0), "R13");

    // R1 revision
    rd(12'h000, "R1");

    // R2 order, R7 new-message event visible to every user
    for (int i = 0; i < 3; i++) wr(a_msg(0), 32'hA500_0000 + i, "R2");
    for (int u = 0; u < NU; u++) rd(a_ev(u), "R7");
    rd(a_cnt(0), "R6");
    for (int i = 0; i < 3; i++) rd(a_msg(0), "R2");

    // R4 empty read
    rd(a_msg(0), "R4");
    rd(a_cnt(0), "R4");

    // R3 overfill, R5 full flag, R7 not-full event
    for (int i = 0; i < D + 2; i++) wr(a_msg(1), 32'h5A00_0010 + i, "R3");
    rd(a_cnt(1), "R3");
    rd(a_full(1), "R5");
    wr(a_ev(2), 32'hFF, "R8");
    rd(a_msg(1), "R2");
    rd(a_ev(2), "R7");
    rd(a_full(1), "R5");
    for (int i = 0; i < D - 1; i++) rd(a_msg(1), "R3");

    // R9, R10, R11 enable handling per user
    wr(a_es(0), 32'h0000_0001, "R9");
    wr(a_es(0), 32'h0000_0008, "R9");
    rd(a_es(0), "R9");
    rd(a_ec(0), "R9");
    wr(a_msg(0), 32'h1234_5678, "R11");
    wr(a_es(1), 32'h0000_0004, "R9");
    wr(a_ev(0), 32'h0000_0000, "R8");
    rd(a_ev(0), "R8");
    wr(a_ev(0), 32'h0000_0001, "R8");
    rd(a_ev(0), "R8");
    wr(a_ec(0), 32'h0000_0008, "R10");
    rd(a_es(0), "R10");
    wr(a_msg(1), 32'h0BAD_F00D, "R11");
    wr(a_ec(1), 32'h0000_00FF, "R10");
    rd(a_msg(0), "R2");
    rd(a_msg(1), "R2");

    // R12 unmapped offsets
    wr(12'h03C, 32'hFFFF_FFFF, "R12");
    wr(12'h100, 32'hFFFF_FFFF, "R12");
    wr(12'h140, 32'hFFFF_FFFF, "R12");
    rd(12'h03C, "R12");
    rd(12'h050, "R12");
    rd(12'h13C, "R12");
    rd(12'h004, "R12");
    for (int m = 0; m < NF; m++) rd(a_cnt(m), "R12");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int m = $urandom_range(0, NF - 1);
      int u = $urandom_range(0, NU - 1);
      logic [31:0] d = $urandom;
      logic [11:0] a;
      case ($urandom_range(0, 7))
        0, 1: a = a_msg(m);
        2:    a = a_full(m);
        3:    a = a_cnt(m);
        4:    a = a_ev(u);
        5:    a = a_es(u);
        6:    a = a_ec(u);
        default: a = 12'($urandom_range(0, 511));
      endcase
      if ($urandom_range(0, 1) == 1) step(1, 0, a, d, tag_of(a));
      else                           step(0, 1, a, 0, tag_of(a));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule